// File: doc/BRIEF.md
# Decrement-and-Branch Sequencer

This block is a tiny stored-program engine whose only data operation fuses four steps: read one register, subtract one unless the value is already zero, write the result to a second register, and branch to one of two labels depending on whether the read value was zero. Programs sit in an instruction store indexed by label. Data sits in a separate register file, and a label value never selects a register. Besides the fused operation, the engine has a print operation, which offers one register's value on a valid/ready output, and a halt operation.

A host fills the instruction store and the register file through write ports while the engine is idle. It then pulses `start` and waits for `done`. After the run it reads results back through a register read port. Addition has to be composed from decrements: with a register holding 256, a cell is incremented modulo 256 by decrementing it 255 times, with a path that turns an underflow from zero into 255.

Top module: `onebr_core`

## Requirements
- R1: After reset, `busy`, `done` and `out_valid` are low.
- R2: A `start` pulse while idle clears `done`, raises `busy` and begins execution at label 0. A `start` pulse while busy has no effect.
- R3: A move-decrement that reads zero from its source writes zero into its target register and continues at the zero label.
- R4: A move-decrement that reads a nonzero value v writes v-1 into its target and continues at the nonzero label.
- R5: When source and target are the same register, the old value is read, so the register drops by exactly one per execution.
- R6: A print raises `out_valid` with the named register's value on `out_data`. Both stay unchanged while `out_ready` is low. Exactly one transfer is made, and execution then continues at the print's next label.
- R7: A halt sets `done` and drops `busy`. After it, no further print transfer or register change occurs.
- R8: Instruction word layout: bits [25:24] opcode (0 move-decrement, 1 print, 2 halt, 3 also halts), [23:20] source register, [19:16] target register, [15:8] zero label (also the print's next label), [7:0] nonzero label. Label fields address only the instruction store.
- R9: Host writes to the instruction store or the register file are accepted only while `busy` is low. Writes made while busy are dropped.
- R10: Registers are 16 bits wide and hold 256, so the 255-decrement increment program gives (x+1) mod 256, including 255 to 0 and 0 to 1.
- R11: Each move-decrement takes exactly two cycles (fetch, then execute). For a one-instruction program followed by halt, `done` rises on the fourth rising edge after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run at label 0 |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | 8 | Instruction store write label |
| prog_wdata | input | 26 | Instruction word to write |
| reg_we | input | 1 | Register file write enable |
| reg_waddr | input | 4 | Register to write |
| reg_wdata | input | 16 | Register write value |
| reg_raddr | input | 4 | Register to read back |
| reg_rdata | output | 16 | Read-back value |
| out_valid | output | 1 | Print value offered |
| out_ready | input | 1 | Consumer accepts the print value |
| out_data | output | 16 | Printed register value |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run ended on a halt |

## Verification
A host register write and an execute-stage write-back can land in the same cycle. The bench provokes this by holding `reg_we` high with a conflicting value on the loop counter during a whole countdown run. It then judges the result from the printed sequence and from the counter's final read-back value, both of which must match a run with no host interference. A `start` pulse can likewise coincide with a stalled print. The bench checks that the pending value and the order of values in the scoreboard are unchanged.

// File: rtl/onebr_pkg.sv
// Shared widths, opcodes and instruction word layout for the sequencer.
// Assumes a single clock domain; all fields are fixed-position in the word.
package onebr_pkg;
    localparam int REG_W  = 16;
    localparam int LBL_W  = 8;
    localparam int RSEL_W = 4;

    typedef enum logic [1:0] {
        OP_MOVDEC = 2'd0,
        OP_PRINT  = 2'd1,
        OP_HALT   = 2'd2,
        OP_RSVD   = 2'd3
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [RSEL_W-1:0] src;
        logic [RSEL_W-1:0] tgt;
        logic [LBL_W-1:0]  lbl_z;
        logic [LBL_W-1:0]  lbl_nz;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_EXEC  = 3'd2,
        ST_PRINT = 3'd3
    } state_e;
endpackage

// File: rtl/onebr_imem.sv
// Instruction store indexed by label. Written synchronously by the host,
// read combinationally by the sequencer. Assumes writes gated by caller.
module onebr_imem
    import onebr_pkg::*;
#(
    parameter int AW = LBL_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  instr_t        wdata,
    input  logic [AW-1:0] raddr,
    output instr_t        rdata
);
    instr_t mem [DEPTH];

    // Store one instruction word per write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/onebr_regfile.sv
// Data register file: one write port, two combinational read ports
// (execute and host read-back). Assumes a single writer per cycle.
module onebr_regfile
    import onebr_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int SW = RSEL_W,
    localparam int NREG = 1 << SW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [SW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] regs [NREG];

    // Commit the selected write at the clock edge.
    always_ff @(posedge clk) begin
        if (we) regs[waddr] <= wdata;
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

    // R4/R3: a write issued in one cycle is visible in the next.
    a_r4_write_lands: assert property (@(posedge clk)
        we |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/onebr_seq.sv
// Fetch/execute sequencer: holds the label counter and instruction register,
// decides branches, write-back and print handshake. Assumes the register
// value for ir.src is presented combinationally on src_val.
module onebr_seq
    import onebr_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int LW = LBL_W,
    parameter int SW = RSEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  instr_t        instr,
    input  logic [DW-1:0] src_val,
    input  logic          out_ready,
    output logic [LW-1:0] pc,
    output logic [SW-1:0] src_sel,
    output logic          ex_we,
    output logic [SW-1:0] ex_waddr,
    output logic [DW-1:0] ex_wdata,
    output logic          out_valid,
    output logic          busy,
    output logic          done
);
    state_e state;
    instr_t ir;
    logic   src_zero;

    assign src_zero = (src_val == '0);

    // Advance the fetch/execute/print state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pc    <= '0;
            ir    <= '0;
            done  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        pc    <= '0;
                        done  <= 1'b0;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    ir    <= instr;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    case (ir.op)
                        OP_MOVDEC: begin
                            pc    <= src_zero ? ir.lbl_z : ir.lbl_nz;
                            state <= ST_FETCH;
                        end
                        OP_PRINT: state <= ST_PRINT;
                        default: begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    endcase
                end
                ST_PRINT: begin
                    if (out_ready) begin
                        pc    <= ir.lbl_z;
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode write-back and handshake outputs from the current state.
    always_comb begin
        src_sel   = ir.src;
        ex_we     = (state == ST_EXEC) && (ir.op == OP_MOVDEC);
        ex_waddr  = ir.tgt;
        ex_wdata  = src_zero ? '0 : src_val - 1'b1;
        out_valid = (state == ST_PRINT);
        busy      = (state != ST_IDLE);
    end

    // R11: fetch is always followed by execute.
    a_r11_fetch_then_exec: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH |=> state == ST_EXEC);
    // R2: an idle start restarts at label 0 with done cleared.
    a_r2_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_FETCH && pc == '0 && !done));
    // R7: done is only ever seen while idle.
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R6: a stalled print holds state and label.
    a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRINT && !out_ready) |=> (state == ST_PRINT && $stable(pc)));
endmodule

// File: rtl/onebr_core.sv
// Top of the decrement-and-branch sequencer: joins instruction store,
// register file and sequencer, and gates host writes to idle periods.
// Assumes the host only loads while busy is low (later writes are dropped).
module onebr_core
    import onebr_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int LW = LBL_W,
    parameter int SW = RSEL_W,
    localparam int IW = INSTR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          prog_we,
    input  logic [LW-1:0] prog_addr,
    input  logic [IW-1:0] prog_wdata,
    input  logic          reg_we,
    input  logic [SW-1:0] reg_waddr,
    input  logic [DW-1:0] reg_wdata,
    input  logic [SW-1:0] reg_raddr,
    output logic [DW-1:0] reg_rdata,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          busy,
    output logic          done
);
    instr_t        cur_instr;
    logic [LW-1:0] pc;
    logic [SW-1:0] src_sel;
    logic          ex_we;
    logic [SW-1:0] ex_waddr;
    logic [DW-1:0] ex_wdata;
    logic [DW-1:0] src_val;
    logic          rf_we;
    logic [SW-1:0] rf_waddr;
    logic [DW-1:0] rf_wdata;

    // Pick execute write-back while running, host write otherwise.
    always_comb begin
        rf_we    = ex_we | (reg_we & ~busy);
        rf_waddr = ex_we ? ex_waddr : reg_waddr;
        rf_wdata = ex_we ? ex_wdata : reg_wdata;
    end

    onebr_imem #(.AW(LW)) imem_i (
        .clk   (clk),
        .we    (prog_we & ~busy),
        .waddr (prog_addr),
        .wdata (instr_t'(prog_wdata)),
        .raddr (pc),
        .rdata (cur_instr)
    );

    onebr_regfile #(.DW(DW), .SW(SW)) rf_i (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (src_sel),
        .rdata_a (src_val),
        .raddr_b (reg_raddr),
        .rdata_b (reg_rdata)
    );

    onebr_seq #(.DW(DW), .LW(LW), .SW(SW)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .instr     (cur_instr),
        .src_val   (src_val),
        .out_ready (out_ready),
        .pc        (pc),
        .src_sel   (src_sel),
        .ex_we     (ex_we),
        .ex_waddr  (ex_waddr),
        .ex_wdata  (ex_wdata),
        .out_valid (out_valid),
        .busy      (busy),
        .done      (done)
    );

    assign out_data = src_val;

    // R6: offered print data stays put until accepted.
    a_r6_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R7: nothing is printed while idle.
    a_r7_no_print_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid);
endmodule

// File: tb/onebr_core_tb.sv
// Scoreboard bench: tasks queue expected print values, a monitor pops and
// compares them at each accepted transfer.
module onebr_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        prog_we = 1'b0;
    logic [7:0]  prog_addr = '0;
    logic [25:0] prog_wdata = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [15:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [15:0] reg_rdata;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;
    logic        busy;
    logic        done;

    int checks = 0;
    int failures = 0;
    int xfers = 0;
    int cycles = 0;
    logic [15:0] exp_q [$];

    onebr_core dut_i (.*);

    always #2 clk = ~clk;

    function automatic logic [25:0] mk(input logic [1:0] op, input logic [3:0] s,
                                      input logic [3:0] t, input logic [7:0] lz,
                                      input logic [7:0] lnz);
        return {op, s, t, lz, lnz};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic load_ins(input logic [7:0] a, input logic [25:0] w);
        step();
        prog_we = 1'b1; prog_addr = a; prog_wdata = w;
        step();
        prog_we = 1'b0;
    endtask

    task automatic load_reg(input logic [3:0] a, input logic [15:0] v);
        step();
        reg_we = 1'b1; reg_waddr = a; reg_wdata = v;
        step();
        reg_we = 1'b0;
    endtask

    task automatic read_reg(input string tag, input logic [3:0] a, input logic [15:0] exp);
        step();
        reg_raddr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic expect_print(input logic [15:0] v);
        exp_q.push_back(v);
    endtask

    task automatic run_wait(input string tag);
        step();
        start = 1'b1;
        step();
        start = 1'b0;
        chk({tag, " R2 done cleared"}, done, 1'b0);
        for (int i = 0; i < 20000 && !done; i++) step();
        chk({tag, " R7 done"}, done, 1'b1);
        chk({tag, " R7 idle"}, busy, 1'b0);
    endtask

    // Monitor: pop and compare on every accepted transfer.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            xfers++;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R6 unexpected print got=%0h exp=none", out_data);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if (out_data !== e) begin
                    failures++;
                    $display("FAIL R6 print value got=%0h exp=%0h", out_data, e);
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog got=%0d exp=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        // R1 reset state
        chk("R1 busy", busy, 1'b0);
        chk("R1 done", done, 1'b0);
        chk("R1 out_valid", out_valid, 1'b0);
        rst_n = 1'b1;

        // Countdown with zero-write to another target (R3, R4, R5, R8, R9)
        load_reg(4'd1, 16'd3);
        load_reg(4'd6, 16'd77);
        load_ins(8'd0, mk(2'd0, 4'd1, 4'd1, 8'd3, 8'd1));
        load_ins(8'd1, mk(2'd1, 4'd1, 4'd0, 8'd0, 8'd0));
        load_ins(8'd3, mk(2'd0, 4'd1, 4'd6, 8'd4, 8'd4));
        load_ins(8'd4, mk(2'd2, 4'd0, 4'd0, 8'd0, 8'd0));
        expect_print(16'd2); expect_print(16'd1); expect_print(16'd0);
        xfers = 0;
        // R9: conflicting host write held during the whole run
        fork
            run_wait("countdown");
            begin
                step();
                step();
                reg_we = 1'b1; reg_waddr = 4'd1; reg_wdata = 16'd99;
                prog_we = 1'b1; prog_addr = 8'd1; prog_wdata = mk(2'd2, 4'd0, 4'd0, 8'd0, 8'd0);
                while (busy) step();
                reg_we = 1'b0; prog_we = 1'b0;
            end
        join
        chk("R6 countdown transfers", xfers, 3);
        read_reg("R5 R9 counter final", 4'd1, 16'd0);
        read_reg("R3 zero into target", 4'd6, 16'd0);
        repeat (20) step();
        chk("R7 stays halted", done, 1'b1);
        chk("R7 no extra prints", xfers, 3);
        read_reg("R7 regs frozen", 4'd1, 16'd0);

        // R11 timing: one move-decrement then halt
        load_reg(4'd7, 16'd4);
        load_ins(8'd0, mk(2'd0, 4'd7, 4'd7, 8'd1, 8'd1));
        load_ins(8'd1, mk(2'd2, 4'd0, 4'd0, 8'd0, 8'd0));
        step();
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (3) step();
        chk("R11 done not yet", done, 1'b0);
        step();
        chk("R11 done on 4th edge", done, 1'b1);
        read_reg("R4 R5 self decrement", 4'd7, 16'd3);

        // R6 back-pressure, R2 start while busy
        load_reg(4'd8, 16'hBEEF);
        load_ins(8'd0, mk(2'd1, 4'd8, 4'd0, 8'd1, 8'd0));
        load_ins(8'd1, mk(2'd2, 4'd0, 4'd0, 8'd0, 8'd0));
        out_ready = 1'b0;
        xfers = 0;
        step();
        start = 1'b1;
        step();
        start = 1'b0;
        repeat (8) step();
        chk("R6 valid held", out_valid, 1'b1);
        chk("R6 data held", out_data, 16'hBEEF);
        start = 1'b1;
        step();
        start = 1'b0;
        repeat (3) step();
        chk("R2 start ignored while busy", out_valid, 1'b1);
        chk("R6 no transfer while stalled", xfers, 0);
        expect_print(16'hBEEF);
        out_ready = 1'b1;
        for (int i = 0; i < 50 && !done; i++) step();
        chk("R7 print then halt", done, 1'b1);
        chk("R6 single transfer", xfers, 1);

        // R10 increment modulo 256 via 255 decrements
        load_reg(4'd2, 16'd256);
        load_ins(8'd0, mk(2'd0, 4'd2, 4'd4, 8'd1, 8'd1));
        load_ins(8'd1, mk(2'd0, 4'd4, 4'd4, 8'd4, 8'd2));
        load_ins(8'd2, mk(2'd0, 4'd3, 4'd3, 8'd3, 8'd1));
        load_ins(8'd3, mk(2'd0, 4'd2, 4'd3, 8'd5, 8'd1));
        load_ins(8'd4, mk(2'd1, 4'd3, 4'd0, 8'd5, 8'd0));
        load_ins(8'd5, mk(2'd2, 4'd0, 4'd0, 8'd0, 8'd0));
        for (int k = 0; k < 3; k++) begin
            logic [15:0] x;
            x = (k == 0) ? 16'd5 : (k == 1) ? 16'd255 : 16'd0;
            load_reg(4'd3, x);
            expect_print((x + 16'd1) & 16'hFF);
            run_wait("R10 increment");
            read_reg("R10 cell", 4'd3, (x + 16'd1) & 16'hFF);
        end
        read_reg("R10 constant kept", 4'd2, 16'd256);

        // R8 reserved opcode halts
        load_ins(8'd0, mk(2'd3, 4'd0, 4'd0, 8'd0, 8'd0));
        run_wait("R8 opcode 3");

        chk("R6 scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule